// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of address translations. A requester presents a virtual page number, a page offset and the identifier of the address space it runs in. Every stored entry is compared in parallel against the page number and the identifier. On a hit, the block returns the physical address in the same cycle. That address is the stored frame number with the unchanged offset appended below it. On a miss, a miss flag is raised so that an external page-table walker can fetch the translation. The walker then writes the translation back through a refill port.

Entries carry their address-space identifier, so translations that belong to different processes can live side by side. A context switch therefore does not need a flush. Two maintenance commands are available. One invalidates everything. The other invalidates only the entries tagged with a given identifier. Refills never create duplicate keys. They prefer empty slots, and once the cache is full they evict entries in round-robin order.

Top module: `tlb_asid_xlate`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss.
- R2: On a hit, `pa_o` equals the matching entry's frame number in the upper bits concatenated with `lk_off_i` in the lower `OFF_W` bits, in the same cycle the lookup is presented.
- R3: While `lk_valid_i` is high exactly one of `hit_o` and `miss_o` is high; while it is low both are low. A lookup whose page number and identifier match no valid entry reports a miss.
- R4: An entry hits only when both its page number and its identifier equal the request, so the same page number under another identifier misses, and the two can coexist.
- R5: A refill with no matching key is written to the lowest-numbered invalid entry when one exists, and then no valid entry is displaced.
- R6: When all entries are valid and the key is new, the refill replaces the entry indexed by a victim pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, only when it is used.
- R7: A refill whose page number and identifier equal a valid entry's key overwrites that entry; no other entry is displaced and no duplicate forms.
- R8: A flush-all command invalidates every entry from the next cycle.
- R9: A flush-by-identifier command invalidates exactly the entries tagged with `fl_asid_i`; all others keep hitting.
- R10: A refill with `rf_vbit_i` low writes an invalid entry, which removes an existing translation for that key.
- R11: A refill becomes visible to lookups from the cycle after it is presented; a lookup in the same cycle sees the old contents.
- R12: When flush-all and a refill arrive together, the refill is dropped. When flush-by-identifier and a refill arrive together, the refill is kept even if its identifier is the flushed one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request strobe |
| lk_vpn_i | input | VPN_W | Lookup virtual page number |
| lk_off_i | input | OFF_W | Lookup page offset |
| lk_asid_i | input | ASID_W | Lookup address-space identifier |
| hit_o | output | 1 | Lookup found a translation |
| miss_o | output | 1 | Lookup found no translation |
| pa_o | output | PFN_W+OFF_W | Physical address on hit, zero otherwise |
| rf_valid_i | input | 1 | Refill write strobe |
| rf_vpn_i | input | VPN_W | Refill page number |
| rf_pfn_i | input | PFN_W | Refill frame number |
| rf_asid_i | input | ASID_W | Refill identifier |
| rf_vbit_i | input | 1 | Valid bit stored with the refill |
| fl_all_i | input | 1 | Invalidate all entries |
| fl_asid_en_i | input | 1 | Invalidate entries of one identifier |
| fl_asid_i | input | ASID_W | Identifier to invalidate |

## Verification
Three of the block's functions can coincide in one cycle, and in each case two of them are paired. A refill can meet a lookup of the same key. It can also meet either flush command. The bench presents a refill and a lookup of the same new key in the same cycle and expects a miss then and a hit one cycle later. It pairs a refill with flush-by-identifier of the refill's own identifier and expects the refilled key to survive while older entries of that identifier are gone. It pairs a refill with flush-all and expects the refilled key to be absent.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    SRC_MATCH  = 2'd0,
    SRC_FREE   = 2'd1,
    SRC_VICTIM = 2'd2
  } slot_src_e;
endpackage

// File: rtl/tlb_cam_entry.sv
module tlb_cam_entry #(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 16,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all_i,
  input  logic              clr_asid_en_i,
  input  logic [ASID_W-1:0] clr_asid_i,
  input  logic              wr_en_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [PFN_W-1:0]  wr_pfn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_vbit_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              lk_match_o,
  output logic              rf_match_o,
  output logic              vld_o,
  output logic [PFN_W-1:0]  pfn_o
);
  logic              vld_q, vld_d;
  logic [VPN_W-1:0]  vpn_q, vpn_d;
  logic [PFN_W-1:0]  pfn_q, pfn_d;
  logic [ASID_W-1:0] asid_q, asid_d;
  logic              en;

  always_comb begin
    vld_d  = vld_q;
    vpn_d  = vpn_q;
    pfn_d  = pfn_q;
    asid_d = asid_q;
    en     = 1'b0;
    if (clr_all_i) begin
      vld_d = 1'b0;
      en    = 1'b1;
    end else if (wr_en_i) begin
      vld_d  = wr_vbit_i;
      vpn_d  = wr_vpn_i;
      pfn_d  = wr_pfn_i;
      asid_d = wr_asid_i;
      en     = 1'b1;
    end else if (clr_asid_en_i && asid_q == clr_asid_i) begin
      vld_d = 1'b0;
      en    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      vpn_q  <= '0;
      pfn_q  <= '0;
      asid_q <= '0;
    end else if (en) begin
      vld_q  <= vld_d;
      vpn_q  <= vpn_d;
      pfn_q  <= pfn_d;
      asid_q <= asid_d;
    end
  end

  assign lk_match_o = vld_q && vpn_q == lk_vpn_i && asid_q == lk_asid_i;
  assign rf_match_o = vld_q && vpn_q == wr_vpn_i && asid_q == wr_asid_i;
  assign vld_o      = vld_q;
  assign pfn_o      = pfn_q;
endmodule

// File: rtl/tlb_slot_pick.sv
module tlb_slot_pick
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_i,
  input  logic [ENTRIES-1:0] rf_match_i,
  input  logic [ENTRIES-1:0] vld_i,
  output logic [ENTRIES-1:0] sel_o,
  output slot_src_e          src_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d, free_idx;
  logic             free_any;

  always_comb begin
    free_idx = '0;
    free_any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_i[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
    end
    sel_o = '0;
    if (|rf_match_i) begin
      sel_o = rf_match_i;
      src_o = SRC_MATCH;
    end else if (free_any) begin
      sel_o[free_idx] = 1'b1;
      src_o = SRC_FREE;
    end else begin
      sel_o[ptr_q] = 1'b1;
      src_o = SRC_VICTIM;
    end
    ptr_d = ptr_q;
    if (commit_i && src_o == SRC_VICTIM)
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (commit_i && src_o == SRC_VICTIM)
      ptr_q <= ptr_d;
  end

  p_victim_only_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_o == SRC_VICTIM) |-> (&vld_i));
  p_match_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rf_match_i));
endmodule

// File: rtl/tlb_asid_xlate.sv
module tlb_asid_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid_i,
  input  logic [VPN_W-1:0]       lk_vpn_i,
  input  logic [OFF_W-1:0]       lk_off_i,
  input  logic [ASID_W-1:0]      lk_asid_i,
  output logic                   hit_o,
  output logic                   miss_o,
  output logic [PFN_W+OFF_W-1:0] pa_o,
  input  logic                   rf_valid_i,
  input  logic [VPN_W-1:0]       rf_vpn_i,
  input  logic [PFN_W-1:0]       rf_pfn_i,
  input  logic [ASID_W-1:0]      rf_asid_i,
  input  logic                   rf_vbit_i,
  input  logic                   fl_all_i,
  input  logic                   fl_asid_en_i,
  input  logic [ASID_W-1:0]      fl_asid_i
);
  localparam int PA_W = PFN_W + OFF_W;

  logic [ENTRIES-1:0] lk_match, rf_match, vld, sel;
  logic [PFN_W-1:0]   pfn [ENTRIES];
  logic [PFN_W-1:0]   pfn_hit;
  logic               commit;
  slot_src_e          src;

  assign commit = rf_valid_i && !fl_all_i;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    tlb_cam_entry #(.VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_ent (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_all_i    (fl_all_i),
      .clr_asid_en_i(fl_asid_en_i),
      .clr_asid_i   (fl_asid_i),
      .wr_en_i      (commit && sel[g]),
      .wr_vpn_i     (rf_vpn_i),
      .wr_pfn_i     (rf_pfn_i),
      .wr_asid_i    (rf_asid_i),
      .wr_vbit_i    (rf_vbit_i),
      .lk_vpn_i     (lk_vpn_i),
      .lk_asid_i    (lk_asid_i),
      .lk_match_o   (lk_match[g]),
      .rf_match_o   (rf_match[g]),
      .vld_o        (vld[g]),
      .pfn_o        (pfn[g])
    );
  end

  tlb_slot_pick #(.ENTRIES(ENTRIES)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (commit),
    .rf_match_i(rf_match),
    .vld_i     (vld),
    .sel_o     (sel),
    .src_o     (src)
  );

  always_comb begin
    pfn_hit = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) pfn_hit = pfn_hit | pfn[i];
  end

  assign hit_o  = lk_valid_i && (|lk_match);
  assign miss_o = lk_valid_i && !(|lk_match);
  assign pa_o   = hit_o ? {pfn_hit, lk_off_i} : PA_W'(0);

  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid_i |-> (hit_o ^ miss_o));
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid_i |-> (!hit_o && !miss_o));
  p_no_dup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fl_all_i |=> (vld == '0));
  p_refill_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && rf_vbit_i) |=> (|vld));
endmodule

// File: tb/tlb_asid_xlate_tb.sv
module tlb_asid_xlate_tb_top;
  localparam int VW = 20, PW = 16, OW = 12, AW = 8, N = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic lk_valid, hit, miss, rf_valid, rf_vbit, fl_all, fl_asid_en;
  logic [VW-1:0] lk_vpn, rf_vpn;
  logic [OW-1:0] lk_off;
  logic [AW-1:0] lk_asid, rf_asid, fl_asid;
  logic [PW-1:0] rf_pfn;
  logic [PW+OW-1:0] pa;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tlb_asid_xlate #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .OFF_W(OW), .ASID_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid_i(lk_valid), .lk_vpn_i(lk_vpn), .lk_off_i(lk_off), .lk_asid_i(lk_asid),
    .hit_o(hit), .miss_o(miss), .pa_o(pa),
    .rf_valid_i(rf_valid), .rf_vpn_i(rf_vpn), .rf_pfn_i(rf_pfn), .rf_asid_i(rf_asid),
    .rf_vbit_i(rf_vbit), .fl_all_i(fl_all), .fl_asid_en_i(fl_asid_en), .fl_asid_i(fl_asid)
  );

  // vector: vpn, asid, offset, expected hit, expected frame
  localparam int VL = VW + AW + OW + 1 + PW;
  localparam logic [VL-1:0] VEC [6] = '{
    {20'h00100, 8'd1, 12'h123, 1'b1, 16'h0A00},
    {20'h00107, 8'd1, 12'hFFF, 1'b1, 16'h0A07},
    {20'h00103, 8'd2, 12'h000, 1'b1, 16'h0A03},
    {20'h00103, 8'd1, 12'h456, 1'b0, 16'h0000},
    {20'h00108, 8'd1, 12'h001, 1'b0, 16'h0000},
    {20'h00101, 8'd2, 12'h7A5, 1'b0, 16'h0000}
  };

  task automatic look(input logic [VW-1:0] v, input logic [AW-1:0] a, input logic [OW-1:0] o,
                      input bit eh, input logic [PW-1:0] ep, input string tag);
    lk_valid = 1'b1; lk_vpn = v; lk_asid = a; lk_off = o;
    #1;
    total++;
    if (eh) begin
      if (!(hit && !miss && pa == {ep, o})) begin
        bad++;
        $display("FAIL %s vpn=%h asid=%0d: hit=%b miss=%b pa=%h expected hit pa=%h",
                 tag, v, a, hit, miss, pa, {ep, o});
      end
    end else if (!(!hit && miss)) begin
      bad++;
      $display("FAIL %s vpn=%h asid=%0d: hit=%b miss=%b expected miss", tag, v, a, hit, miss);
    end
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [VW-1:0] v, input logic [PW-1:0] p, input logic [AW-1:0] a,
                      input bit vb);
    rf_valid = 1'b1; rf_vpn = v; rf_pfn = p; rf_asid = a; rf_vbit = vb;
    @(negedge clk);
    rf_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, got no end, expected end");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lk_valid = 0; lk_vpn = 0; lk_off = 0; lk_asid = 0;
    rf_valid = 0; rf_vpn = 0; rf_pfn = 0; rf_asid = 0; rf_vbit = 0;
    fl_all = 0; fl_asid_en = 0; fl_asid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty after reset
    look(20'h00100, 8'd1, 12'h0, 0, 0, "R1");
    // R3: idle lookup drives neither flag
    #1; total++;
    if (hit || miss) begin
      bad++; $display("FAIL R3 idle: hit=%b miss=%b expected 0 0", hit, miss);
    end
    @(negedge clk);

    for (int i = 0; i < N; i++)
      fill(20'h00100 + VW'(i), 16'h0A00 + PW'(i), (i == 3) ? 8'd2 : 8'd1, 1'b1);

    // R2 R3 R4: table walk
    for (int k = 0; k < 6; k++)
      look(VEC[k][VL-1 -: VW], VEC[k][VL-VW-1 -: AW], VEC[k][PW+OW : PW+1],
           VEC[k][PW], VEC[k][PW-1:0], "R2/R3/R4 table");

    // R9: flush identifier 2
    fl_asid_en = 1'b1; fl_asid = 8'd2;
    @(negedge clk);
    fl_asid_en = 1'b0;
    look(20'h00103, 8'd2, 12'h0, 0, 0, "R9 flushed");
    look(20'h00100, 8'd1, 12'h5, 1, 16'h0A00, "R9 kept");

    // R5: new key goes to the freed slot, nothing displaced
    fill(20'h00200, 16'h0B00, 8'd1, 1'b1);
    look(20'h00200, 8'd1, 12'h9, 1, 16'h0B00, "R5 new");
    for (int i = 0; i < N; i++)
      if (i != 3) look(20'h00100 + VW'(i), 8'd1, 12'h1, 1, 16'h0A00 + PW'(i), "R5 kept");

    // R7: duplicate key overwrites in place
    fill(20'h00101, 16'h0C01, 8'd1, 1'b1);
    look(20'h00101, 8'd1, 12'h2, 1, 16'h0C01, "R7 new frame");
    look(20'h00100, 8'd1, 12'h2, 1, 16'h0A00, "R7 kept");
    look(20'h00200, 8'd1, 12'h2, 1, 16'h0B00, "R7 kept");

    // R6: full, victim pointer at entry 0 then 1
    fill(20'h00300, 16'h0D00, 8'd1, 1'b1);
    look(20'h00100, 8'd1, 12'h3, 0, 0, "R6 evict slot0");
    look(20'h00300, 8'd1, 12'h3, 1, 16'h0D00, "R6 new");
    look(20'h00101, 8'd1, 12'h3, 1, 16'h0C01, "R6 kept");
    fill(20'h00301, 16'h0D01, 8'd1, 1'b1);
    look(20'h00101, 8'd1, 12'h3, 0, 0, "R6 evict slot1");
    look(20'h00102, 8'd1, 12'h3, 1, 16'h0A02, "R6 kept");

    // R10: refill with valid bit low removes the key
    fill(20'h00102, 16'h0E02, 8'd1, 1'b0);
    look(20'h00102, 8'd1, 12'h4, 0, 0, "R10 removed");
    look(20'h00104, 8'd1, 12'h4, 1, 16'h0A04, "R10 kept");

    // R11: refill and lookup together
    rf_valid = 1'b1; rf_vpn = 20'h00400; rf_pfn = 16'h0F00; rf_asid = 8'd1; rf_vbit = 1'b1;
    look(20'h00400, 8'd1, 12'h6, 0, 0, "R11 same cycle");
    rf_valid = 1'b0;
    look(20'h00400, 8'd1, 12'h6, 1, 16'h0F00, "R11 next cycle");

    // R12: refill with flush-by-identifier of the same identifier survives
    rf_valid = 1'b1; rf_vpn = 20'h00500; rf_pfn = 16'h0F05; rf_asid = 8'd1; rf_vbit = 1'b1;
    fl_asid_en = 1'b1; fl_asid = 8'd1;
    @(negedge clk);
    rf_valid = 1'b0; fl_asid_en = 1'b0;
    look(20'h00500, 8'd1, 12'h7, 1, 16'h0F05, "R12 asid flush keeps refill");
    look(20'h00104, 8'd1, 12'h7, 0, 0, "R9/R12 old gone");

    // R12 R8: refill with flush-all is dropped, everything cleared
    rf_valid = 1'b1; rf_vpn = 20'h00600; rf_pfn = 16'h0F06; rf_asid = 8'd3; rf_vbit = 1'b1;
    fl_all = 1'b1;
    @(negedge clk);
    rf_valid = 1'b0; fl_all = 1'b0;
    look(20'h00600, 8'd3, 12'h8, 0, 0, "R12 refill dropped");
    look(20'h00500, 8'd1, 12'h8, 0, 0, "R8 cleared");
    look(20'h00103, 8'd1, 12'h8, 0, 0, "R8 cleared");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule